// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two binary floating-point encodings and returns their product as an encoding of the same format. Each operand has a sign bit in the most significant position, then an `EXP_W`-bit biased exponent, then an `FRAC_W`-bit fraction in the low bits. The defaults (8 and 23) give the common 32-bit single-precision layout with bias 127. Operands with a non-zero, non-maximal exponent are normal numbers with an implied leading one. An all-zero exponent field means zero, and any fraction bits beside it are discarded.

The datapath is a two-stage pipeline. The first stage classifies both operands and forms the result sign. It adds the two biased exponents and subtracts the bias in the same step, and it multiplies the two full significands. The second stage shifts the double-width product at most once so that it has a single integer digit. It then rounds to nearest with ties to even, builds the packed result, and raises an overflow or underflow flag when the final exponent leaves the encodable range. A valid strobe travels alongside the data, so a new operand pair can enter on every cycle.

Top module: `fpm_top`

## Requirements
- R1: The result sign is the XOR of the two operand signs (bit `EXP_W+FRAC_W`) for every result except NaN.
- R2: For two normal operands the result is the exact product rounded to `FRAC_W` fraction bits, with result exponent = ea + eb − bias (bias = 2^(EXP_W−1) − 1) plus any normalization increments.
- R3: An operand whose exponent field is zero counts as zero whatever its fraction. Such an operand times a finite operand gives a zero with the R1 sign, and neither flag is set.
- R4: When the significand product is 2.0 or more it is shifted right by one place and the exponent is incremented.
- R5: Rounding is to nearest. An exact halfway case rounds to the neighbour whose fraction LSB is 0.
- R6: When rounding carries out of an all-ones fraction, the fraction becomes zero and the exponent is incremented once more.
- R7: A final exponent above 2^EXP_W − 2 gives an infinity (exponent all ones, fraction zero) with the R1 sign and sets `ovf_flag`.
- R8: A final exponent below 1 gives a zero with the R1 sign and sets `unf_flag`. The two flags are never set together.
- R9: An all-ones exponent field marks a special operand: infinity if the fraction is zero, NaN otherwise. A NaN operand, or infinity times zero, gives the NaN encoding: sign 0, exponent all ones, fraction MSB 1, other fraction bits 0. Otherwise an infinite operand gives an infinity with the R1 sign. Both flags stay clear in these cases.
- R10: A pair accepted with `in_vld` high appears on the outputs, with `out_vld` high, exactly two clock edges later. `out_vld` is high in no other cycle. A synchronous reset clears `out_vld`, `result` and both flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand pair valid |
| op_a | input | 1+EXP_W+FRAC_W | First operand encoding |
| op_b | input | 1+EXP_W+FRAC_W | Second operand encoding |
| out_vld | output | 1 | Result valid, two cycles after `in_vld` |
| result | output | 1+EXP_W+FRAC_W | Product encoding |
| ovf_flag | output | 1 | Exponent overflow, result is infinity |
| unf_flag | output | 1 | Exponent underflow, result is zero |

## Verification
Properties checked on every cycle:
- The output sign matches the XOR of the operand signs from two cycles earlier.
- A zero operand leads to a zero magnitude.
- An overflow always carries the infinity pattern, and an underflow always carries a zero pattern; the two flags never rise together.
- A finite product always reaches normalization with a leading one.
- A valid output always follows a valid input by two cycles.

The numeric correctness of the rounded fraction and exponent can only be shown by scenarios that compare against an independent integer model of the exact product. This includes ties resolved to even and the carry out of an all-ones fraction. Those scenarios sweep every operand pair of a 4-bit-exponent, 3-bit-fraction instance, and run directed and random pairs through the 32-bit instance.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    // Class of one operand encoding
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } op_cls_e;

    // What kind of result the pair produces before the exponent range is known
    typedef enum logic [1:0] {
        RK_FIN  = 2'd0,
        RK_ZERO = 2'd1,
        RK_INF  = 2'd2,
        RK_NAN  = 2'd3
    } res_kind_e;

    // Priority: NaN (incl. inf x zero) > inf > zero > finite
    function automatic res_kind_e resolve_kind(input op_cls_e ca, input op_cls_e cb);
        res_kind_e k;
        if (ca == CLS_NAN || cb == CLS_NAN)
            k = RK_NAN;
        else if ((ca == CLS_INF && cb == CLS_ZERO) || (cb == CLS_INF && ca == CLS_ZERO))
            k = RK_NAN;
        else if (ca == CLS_INF || cb == CLS_INF)
            k = RK_INF;
        else if (ca == CLS_ZERO || cb == CLS_ZERO)
            k = RK_ZERO;
        else
            k = RK_FIN;
        return k;
    endfunction

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op,
    output logic                  sgn,
    output logic [EXP_W-1:0]      expo,
    output logic [FRAC_W:0]       sig,
    output fpm_pkg::op_cls_e      cls
);
    logic [FRAC_W-1:0] frac;
    logic              exp_zero;
    logic              exp_max;

    always_comb begin
        sgn      = op[EXP_W+FRAC_W];
        expo     = op[FRAC_W +: EXP_W];
        frac     = op[FRAC_W-1:0];
        exp_zero = (expo == '0);
        exp_max  = (expo == '1);
        // Hidden one only for a non-zero exponent; zero-exponent fraction is dropped
        sig      = exp_zero ? '0 : {1'b1, frac};
        if (exp_zero)
            cls = fpm_pkg::CLS_ZERO;
        else if (exp_max)
            cls = (frac != '0) ? fpm_pkg::CLS_NAN : fpm_pkg::CLS_INF;
        else
            cls = fpm_pkg::CLS_NORM;
    end

endmodule

// File: rtl/fpm_mulstage.sv
module fpm_mulstage #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int SIG_W = FRAC_W + 1,
    localparam int PW    = 2 * SIG_W,
    localparam int EW2   = EXP_W + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic                     sgn_a,
    input  logic                     sgn_b,
    input  logic [EXP_W-1:0]         exp_a,
    input  logic [EXP_W-1:0]         exp_b,
    input  logic [SIG_W-1:0]         sig_a,
    input  logic [SIG_W-1:0]         sig_b,
    input  fpm_pkg::op_cls_e         cls_a,
    input  fpm_pkg::op_cls_e         cls_b,
    output logic                     s1_vld,
    output logic                     s1_sign,
    output fpm_pkg::res_kind_e       s1_kind,
    output logic signed [EW2-1:0]    s1_esum,
    output logic [PW-1:0]            s1_prod
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic signed [EW2-1:0] esum_c;
    logic [PW-1:0]         prod_c;
    fpm_pkg::res_kind_e    kind_c;

    always_comb begin
        // Bias removed once, two guard bits keep the sum signed and unclipped
        esum_c = {2'b00, exp_a} + {2'b00, exp_b} - EW2'(BIAS);
        prod_c = {{SIG_W{1'b0}}, sig_a} * {{SIG_W{1'b0}}, sig_b};
        kind_c = fpm_pkg::resolve_kind(cls_a, cls_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld  <= 1'b0;
            s1_sign <= 1'b0;
            s1_kind <= fpm_pkg::RK_FIN;
            s1_esum <= '0;
            s1_prod <= '0;
        end else begin
            s1_vld  <= in_vld;
            s1_sign <= sgn_a ^ sgn_b;
            s1_kind <= kind_c;
            s1_esum <= esum_c;
            s1_prod <= prod_c;
        end
    end

endmodule

// File: rtl/fpm_rndstage.sv
module fpm_rndstage #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int SIG_W = FRAC_W + 1,
    localparam int PW    = 2 * SIG_W,
    localparam int EW2   = EXP_W + 2,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  s1_vld,
    input  logic                  s1_sign,
    input  fpm_pkg::res_kind_e    s1_kind,
    input  logic signed [EW2-1:0] s1_esum,
    input  logic [PW-1:0]         s1_prod,
    output logic                  out_vld,
    output logic [W-1:0]          result,
    output logic                  ovf_flag,
    output logic                  unf_flag
);
    localparam int EMAX = (1 << EXP_W) - 2;
    localparam logic signed [EW2-1:0] EMAX_S = EW2'(EMAX);
    localparam logic signed [EW2-1:0] EMIN_S = EW2'(1);
    localparam logic [W-1:0] NAN_PAT = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic                  top_c;
    logic [PW-1:0]         norm_c;
    logic [FRAC_W-1:0]     frac_c;
    logic                  guard_c;
    logic                  sticky_c;
    logic                  inc_c;
    logic                  carry_c;
    logic [FRAC_W-1:0]     frac_r;
    logic signed [EW2-1:0] exp_c;
    logic                  ovf_c;
    logic                  unf_c;
    logic [W-1:0]          res_c;
    logic                  ovf_o;
    logic                  unf_o;

    always_comb begin
        // Single-step normalization: product lies in [1,4)
        top_c    = s1_prod[PW-1];
        norm_c   = top_c ? s1_prod : (s1_prod << 1);
        frac_c   = norm_c[PW-2 -: FRAC_W];
        guard_c  = norm_c[PW-2-FRAC_W];
        sticky_c = |norm_c[PW-3-FRAC_W:0];
        // Nearest-even: round up above half, or at half when LSB is odd
        inc_c    = guard_c & (sticky_c | frac_c[0]);
        carry_c  = inc_c & (&frac_c);
        frac_r   = frac_c + FRAC_W'(inc_c);
        exp_c    = s1_esum + EW2'(top_c) + EW2'(carry_c);
        ovf_c    = (exp_c > EMAX_S);
        unf_c    = (exp_c < EMIN_S);
    end

    always_comb begin
        res_c = '0;
        ovf_o = 1'b0;
        unf_o = 1'b0;
        case (s1_kind)
            fpm_pkg::RK_NAN:  res_c = NAN_PAT;
            fpm_pkg::RK_INF:  res_c = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            fpm_pkg::RK_ZERO: res_c = {s1_sign, {(W-1){1'b0}}};
            default: begin
                if (ovf_c) begin
                    res_c = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                    ovf_o = 1'b1;
                end else if (unf_c) begin
                    res_c = {s1_sign, {(W-1){1'b0}}};
                    unf_o = 1'b1;
                end else begin
                    res_c = {s1_sign, exp_c[EXP_W-1:0], frac_r};
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            result   <= '0;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            out_vld  <= s1_vld;
            result   <= res_c;
            ovf_flag <= s1_vld & ovf_o;
            unf_flag <= s1_vld & unf_o;
        end
    end

    // R4: a finite product from the multiplier always normalizes to a leading one
    a_r4_lead_one: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && s1_kind == fpm_pkg::RK_FIN) |-> norm_c[PW-1]);

    // R7: overflow always presents infinity
    a_r7_ovf_inf: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |-> (result[W-2 -: EXP_W] == '1 && result[FRAC_W-1:0] == '0));

    // R8: underflow always presents zero, and never together with overflow
    a_r8_unf_zero: assert property (@(posedge clk) disable iff (rst)
        unf_flag |-> (result[W-2:0] == '0 && !ovf_flag));

    // R3: a zero operand pair leaves a zero magnitude and no flag
    a_r3_zero_in: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && s1_kind == fpm_pkg::RK_ZERO) |=> (result[W-2:0] == '0 && !ovf_flag && !unf_flag));

endmodule

// File: rtl/fpm_top.sv
module fpm_top #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic [EXP_W+FRAC_W:0]   op_a,
    input  logic [EXP_W+FRAC_W:0]   op_b,
    output logic                    out_vld,
    output logic [EXP_W+FRAC_W:0]   result,
    output logic                    ovf_flag,
    output logic                    unf_flag
);
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int SIG_W = FRAC_W + 1;
    localparam int PW    = 2 * SIG_W;
    localparam int EW2   = EXP_W + 2;

    logic [1:0][W-1:0]     ops;
    logic [1:0]            sgn;
    logic [EXP_W-1:0]      expo [2];
    logic [SIG_W-1:0]      sig  [2];
    fpm_pkg::op_cls_e      cls  [2];

    logic                  s1_vld;
    logic                  s1_sign;
    fpm_pkg::res_kind_e    s1_kind;
    logic signed [EW2-1:0] s1_esum;
    logic [PW-1:0]         s1_prod;
    logic                  out_nan;

    assign ops = {op_b, op_a};

    for (genvar k = 0; k < 2; k++) begin : g_unpack
        fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
            .op   (ops[k]),
            .sgn  (sgn[k]),
            .expo (expo[k]),
            .sig  (sig[k]),
            .cls  (cls[k])
        );
    end

    fpm_mulstage #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mul (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .sgn_a   (sgn[0]),
        .sgn_b   (sgn[1]),
        .exp_a   (expo[0]),
        .exp_b   (expo[1]),
        .sig_a   (sig[0]),
        .sig_b   (sig[1]),
        .cls_a   (cls[0]),
        .cls_b   (cls[1]),
        .s1_vld  (s1_vld),
        .s1_sign (s1_sign),
        .s1_kind (s1_kind),
        .s1_esum (s1_esum),
        .s1_prod (s1_prod)
    );

    fpm_rndstage #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rnd (
        .clk      (clk),
        .rst      (rst),
        .s1_vld   (s1_vld),
        .s1_sign  (s1_sign),
        .s1_kind  (s1_kind),
        .s1_esum  (s1_esum),
        .s1_prod  (s1_prod),
        .out_vld  (out_vld),
        .result   (result),
        .ovf_flag (ovf_flag),
        .unf_flag (unf_flag)
    );

    assign out_nan = (result[W-2 -: EXP_W] == '1) && (result[FRAC_W-1:0] != '0);

    // R1: sign of every non-NaN result follows the operand signs two cycles back
    a_r1_sign: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_nan) |-> (result[W-1] == $past(op_a[W-1] ^ op_b[W-1], 2)));

    // R10: a valid output is always preceded by a valid input two edges earlier
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(in_vld, 2));

endmodule

// File: tb/test_fpm_top.sv
module test_fpm_top;

    typedef struct {
        longint r;
        bit     o;
        bit     u;
        string  tag;
        int     stamp;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld_b = 1'b0, vld_s = 1'b0;
    logic [31:0] a_b = '0, b_b = '0;
    logic [7:0]  a_s = '0, b_s = '0;
    logic        ovld_b, ovld_s;
    logic [31:0] res_b;
    logic [7:0]  res_s;
    logic        ovf_b, unf_b, ovf_s, unf_s;

    int   cyc = 0;
    int   nchk = 0;
    int   nfail = 0;
    exp_t q_b[$];
    exp_t q_s[$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    fpm_top i_fpm_top (
        .clk(clk), .rst(rst), .in_vld(vld_b), .op_a(a_b), .op_b(b_b),
        .out_vld(ovld_b), .result(res_b), .ovf_flag(ovf_b), .unf_flag(unf_b)
    );

    fpm_top #(.EXP_W(4), .FRAC_W(3)) i_fpm_top_small (
        .clk(clk), .rst(rst), .in_vld(vld_s), .op_a(a_s), .op_b(b_s),
        .out_vld(ovld_s), .result(res_s), .ovf_flag(ovf_s), .unf_flag(unf_s)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // Integer model: exact product, rounded by remainder comparison
    function automatic void ref_mul(input int E, input int F, input longint a, input longint b,
                                    output longint res, output bit ovf, output bit unf,
                                    output string tag);
        longint one = 1;
        longint mf = (one << F) - 1;
        longint me = (one << E) - 1;
        longint bias = (one << (E - 1)) - 1;
        longint sa = (a >> (E + F)) & 1, sb = (b >> (E + F)) & 1;
        longint ea = (a >> F) & me, eb = (b >> F) & me;
        longint fa = a & mf, fb = b & mf;
        longint s = sa ^ sb;
        bit nan_a = (ea == me) && (fa != 0), nan_b = (eb == me) && (fb != 0);
        bit inf_a = (ea == me) && (fa == 0), inf_b = (eb == me) && (fb == 0);
        bit zer_a = (ea == 0), zer_b = (eb == 0);
        longint p, q, rem, half, e;
        int k, sh;
        bit tie, car, wide;
        ovf = 0; unf = 0;
        if (nan_a || nan_b || (inf_a && zer_b) || (inf_b && zer_a)) begin
            res = (me << F) | (one << (F - 1)); tag = "R9";
        end else if (inf_a || inf_b) begin
            res = (s << (E + F)) | (me << F); tag = "R9";
        end else if (zer_a || zer_b) begin
            res = s << (E + F); tag = "R3";
        end else begin
            p = ((one << F) | fa) * ((one << F) | fb);
            wide = ((p >> (2 * F + 1)) & 1) != 0;
            k = wide ? 2 * F + 1 : 2 * F;
            sh = k - F;
            q = p >> sh;
            rem = p & ((one << sh) - 1);
            half = one << (sh - 1);
            tie = (rem == half);
            if (rem > half || (tie && (q & 1) != 0)) q = q + 1;
            car = 0;
            if (q == (one << (F + 1))) begin q = q >> 1; k = k + 1; car = 1; end
            e = ea + eb - bias + longint'(k - 2 * F);
            if (e > me - 1) begin
                ovf = 1; res = (s << (E + F)) | (me << F); tag = "R7";
            end else if (e < 1) begin
                unf = 1; res = s << (E + F); tag = "R8";
            end else begin
                res = (s << (E + F)) | (e << F) | (q & mf);
                tag = car ? "R6" : (tie ? "R5" : (wide ? "R4" : "R2"));
            end
        end
    endfunction

    task automatic compare(input exp_t e, input int E, input int F,
                           input longint r, input bit o, input bit u);
        longint one = 1;
        longint me = (one << E) - 1;
        bit is_nan = (((e.r >> F) & me) == me) && ((e.r & ((one << F) - 1)) != 0);
        chk(e.tag, "result", r, e.r);
        chk(e.tag, "ovf", longint'(o), longint'(e.o));
        chk(e.tag, "unf", longint'(u), longint'(e.u));
        chk("R10", "latency", longint'(cyc - e.stamp), 2);
        if (!is_nan)
            chk("R1", "sign", (r >> (E + F)) & 1, (e.r >> (E + F)) & 1);
    endtask

    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (ovld_b) begin
                if (q_b.size() == 0) chk("R10", "spurious out_vld (32b)", 1, 0);
                else begin e = q_b.pop_front(); compare(e, 8, 23, longint'(res_b), ovf_b, unf_b); end
            end
            if (ovld_s) begin
                if (q_s.size() == 0) chk("R10", "spurious out_vld (8b)", 1, 0);
                else begin e = q_s.pop_front(); compare(e, 4, 3, longint'(res_s), ovf_s, unf_s); end
            end
        end
    end

    task automatic push_b(input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        longint r; bit o, u; string t;
        @(negedge clk);
        vld_b = 1'b1; a_b = a; b_b = b;
        ref_mul(8, 23, longint'(a), longint'(b), r, o, u, t);
        e.r = r; e.o = o; e.u = u; e.tag = t; e.stamp = cyc;
        q_b.push_back(e);
    endtask

    task automatic push_s(input logic [7:0] a, input logic [7:0] b);
        exp_t e;
        longint r; bit o, u; string t;
        @(negedge clk);
        vld_s = 1'b1; a_s = a; b_s = b;
        ref_mul(4, 3, longint'(a), longint'(b), r, o, u, t);
        e.r = r; e.o = o; e.u = u; e.tag = t; e.stamp = cyc;
        q_s.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vld_b = 1'b0; vld_s = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] ra, rb;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "reset out_vld", longint'(ovld_b), 0);
        chk("R10", "reset result", longint'(res_b), 0);
        chk("R10", "reset flags", longint'({ovf_b, unf_b, ovf_s, unf_s, ovld_s}), 0);
        rst = 1'b0;

        // Directed 32-bit pairs
        push_b(32'hC100_0000, 32'h4180_0000); // R2: -8 * 16, exponent 130+131-127
        push_b(32'h4040_0000, 32'h40A0_0000); // R2: 3 * 5
        push_b(32'h3FFF_FFFF, 32'h3FFF_FFFF); // R4: product near 4
        push_b(32'h0000_0001, 32'h4000_0000); // R3: zero exponent with fraction
        push_b(32'h8000_0000, 32'h40A0_0000); // R3: -0 * 5
        push_b(32'h7F00_0000, 32'h7F00_0000); // R7
        push_b(32'h0080_0000, 32'h0080_0000); // R8
        push_b(32'h7F80_0000, 32'h0000_0000); // R9: inf * 0
        push_b(32'hFF80_0000, 32'h4000_0000); // R9: -inf * 2
        push_b(32'h7FC0_0001, 32'h3F80_0000); // R9: NaN * 1
        push_b(32'h3F80_0001, 32'h3FC0_0000); // R5 region
        idle(1);                              // R10: gap in the stream
        for (int i = 0; i < 4000; i++) begin
            ra = $urandom();
            rb = $urandom();
            if (i % 2 == 0) rb[30:23] = 8'(120 + ($urandom() % 16));
            push_b(ra, rb);
        end
        idle(4);

        // Exhaustive sweep of the small instance: R2..R9 all arise
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++)
                push_s(8'(x), 8'(y));
            if (x % 64 == 0) idle(1);
        end
        idle(5);
        chk("R10", "pending 32b results", q_b.size(), 0);
        chk("R10", "pending 8b results", q_s.size(), 0);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule